// File: doc/BRIEF.md
# Three-Channel Interval Timer Interface

This block sits on a small register bus and holds three 16-bit down-counters. One shared control location picks a counter and sets how its byte-wide data port is accessed: low byte only, high byte only, or low byte followed by high byte. Software loads each divisor one byte at a time through that counter's data port. It reads the count back through the same port, under the same byte rules.

An enabled counter moves one step on every `tick` pulse while its gate is open, and reloads its divisor when it leaves the value 1. Counter 1 has no gate input and always counts. Each time it expires it raises a clock-interrupt flag, unless the external `inhibit_timers` input is high. Reading a dedicated clear location returns zero and drops that flag.

Requests are single-cycle and always accepted, so the bus has no back-pressure. A read returns its byte on `rsp_data`, with `rsp_valid` high, in the cycle after the request. The host must take the response in that cycle. A write returns no response.

Top module: `tmr3_bus`

## Requirements
- R1: After reset every divisor, mode byte, count, enable and byte toggle is zero, `clk_irq` and `rsp_valid` are low, and a control read returns 0.
- R2: Address 3 is the control location, and bits 7:6 of the written byte select the counter. A select value of 3 changes nothing: no mode, enable, toggle, count, or record of the last selected counter.
- R3: A control write with select 0 to 2 stores the whole byte as that counter's mode. It clears the counter's enable and its byte toggle. A control read returns the mode byte of the counter named by the last valid control write.
- R4: Mode bits 5:4 give the access type. With 01 (low only) or 10 (high only), a write to the counter's data port (addresses 0, 1, 2) replaces only that byte of the divisor, keeps the other byte, enables the counter and loads the count from the new divisor.
- R5: With access type 11, the first data write after a control write loads the low byte and leaves the enable as it was. The next data write loads the high byte, enables the counter and loads the count. Every data access flips the toggle.
- R6: A data read follows the same byte selection. With access type 11 it returns the low byte, then the high byte, flipping the toggle on each read. With access type 00 it returns 0 and changes nothing.
- R7: A data read returns the live count while the counter is enabled and its gate is high, and the stored divisor otherwise. Counters 0 and 2 are gated by `gate0` and `gate2`; counter 1 is always gated.
- R8: An enabled, gated counter decrements once per `tick` cycle and reloads its divisor on the tick taken at count 1. A divisor of 0 counts as 65536, so one tick after loading 0 the count reads 0xFFFF.
- R9: Counter 1 expiring sets `clk_irq` on that clock edge when `inhibit_timers` is low, and leaves it unchanged when `inhibit_timers` is high.
- R10: A read of address 4 returns 0 and clears `clk_irq`. A write to address 4 has no effect. When an expiry and the clearing read fall in the same cycle, the flag stays set.
- R11: Every read request gives `rsp_valid` high with its data in the next cycle. `rsp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe, accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | 0..2 data ports, 3 control, 4 interrupt clear |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 8 | Read byte |
| tick | input | 1 | Count-enable pulse shared by all counters |
| gate0 | input | 1 | Gate of counter 0 |
| gate2 | input | 1 | Gate of counter 2 |
| inhibit_timers | input | 1 | Blocks counter 1 from setting the interrupt flag |
| clk_irq | output | 1 | Pending clock-interrupt flag |

## Verification
Most internal state is visible only through data reads, so a wrong count, divisor or enable shows up as a wrong byte on the next read of that counter. A wrong byte toggle shifts every later byte of the two-access sequence by one position, until a control write realigns it. An enable raised too early shows because the counter is read after ticks with the gate open, and an expiry fault shows on `clk_irq` at the very clock edge where the count leaves 1.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NCH    = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR = 3'd4;
endpackage

// File: rtl/tmr3_chan.sv
module tmr3_chan
  import tmr3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tick,
  input  logic              gate,
  output logic [BYTE_W-1:0] mode,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              expire
);
  logic [BYTE_W-1:0] mode_q;
  logic [CNT_W-1:0]  div_q, cnt_q, shown;
  logic              en_q, tog_q, counting;
  acc_e              acc;

  assign acc      = acc_e'(mode_q[5:4]);
  assign counting = en_q && gate && tick && !ctl_wr && !dat_wr;
  assign expire   = counting && (cnt_q == CNT_W'(1));
  assign mode     = mode_q;
  assign shown    = (en_q && gate) ? cnt_q : div_q;

  always_comb begin
    unique case (acc)
      ACC_LO:   rd_byte = shown[BYTE_W-1:0];
      ACC_HI:   rd_byte = shown[CNT_W-1:BYTE_W];
      ACC_LOHI: rd_byte = tog_q ? shown[CNT_W-1:BYTE_W] : shown[BYTE_W-1:0];
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      tog_q  <= 1'b0;
    end else if (ctl_wr) begin
      mode_q <= wbyte;
      en_q   <= 1'b0;
      tog_q  <= 1'b0;
    end else if (dat_wr) begin
      unique case (acc)
        ACC_LO: begin
          div_q[BYTE_W-1:0] <= wbyte;
          cnt_q <= {div_q[CNT_W-1:BYTE_W], wbyte};
          en_q  <= 1'b1;
        end
        ACC_HI: begin
          div_q[CNT_W-1:BYTE_W] <= wbyte;
          cnt_q <= {wbyte, div_q[BYTE_W-1:0]};
          en_q  <= 1'b1;
        end
        ACC_LOHI: begin
          if (tog_q) begin
            div_q[CNT_W-1:BYTE_W] <= wbyte;
            cnt_q <= {wbyte, div_q[BYTE_W-1:0]};
            en_q  <= 1'b1;
          end else begin
            div_q[BYTE_W-1:0] <= wbyte;
          end
          tog_q <= !tog_q;
        end
        default: ;
      endcase
    end else begin
      if (dat_rd && acc == ACC_LOHI) tog_q <= !tog_q;
      if (counting) cnt_q <= (cnt_q == CNT_W'(1)) ? div_q : cnt_q - CNT_W'(1);
    end
  end

  // R3
  ctl_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (!en_q && !tog_q));

  // R5
  low_first_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ctl_wr && acc == ACC_LOHI && !tog_q) |=> $stable(en_q));

  // R6
  toggle_only_lohi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != ACC_LOHI) |-> !tog_q);

  // R8
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && cnt_q != CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == div_q));
endmodule

// File: rtl/tmr3_irq.sv
module tmr3_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic inhibit,
  input  logic clr,
  output logic irq
);
  logic set_req, irq_q;

  assign set_req = expire && !inhibit;
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (set_req) irq_q <= 1'b1;
    else if (clr)     irq_q <= 1'b0;
  end

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> irq_q);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_req) |=> !irq_q);

  // R9
  irq_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !set_req) |=> !irq_q);
endmodule

// File: rtl/tmr3_bus.sv
module tmr3_bus
  import tmr3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              tick,
  input  logic              gate0,
  input  logic              gate2,
  input  logic              inhibit_timers,
  output logic              clk_irq
);
  localparam int SEL_W = 2;

  logic              rd_fire, wr_fire, ctl_ok, clr_rd;
  logic [SEL_W-1:0]  sel_q, sel_in;
  logic [NCH-1:0]    gate_v, expire_v, ctl_v, dwr_v, drd_v;
  logic [BYTE_W-1:0] mode_a [NCH];
  logic [BYTE_W-1:0] byte_a [NCH];
  logic [BYTE_W-1:0] rd_mux, ctl_mux;
  logic              rsp_v_q;
  logic [BYTE_W-1:0] rsp_d_q;

  assign rd_fire = req_valid && !req_write;
  assign wr_fire = req_valid && req_write;
  assign sel_in  = req_wdata[7:6];
  assign ctl_ok  = wr_fire && req_addr == A_CTRL && sel_in != 2'd3;
  assign clr_rd  = rd_fire && req_addr == A_CLEAR;
  assign gate_v  = {gate2, 1'b1, gate0};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctl_v[g] = ctl_ok && sel_in == SEL_W'(g);
    assign dwr_v[g] = wr_fire && req_addr == ADDR_W'(g);
    assign drd_v[g] = rd_fire && req_addr == ADDR_W'(g);
    tmr3_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (ctl_v[g]),
      .dat_wr  (dwr_v[g]),
      .dat_rd  (drd_v[g]),
      .wbyte   (req_wdata),
      .tick    (tick),
      .gate    (gate_v[g]),
      .mode    (mode_a[g]),
      .rd_byte (byte_a[g]),
      .expire  (expire_v[g])
    );
  end

  tmr3_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire_v[1]),
    .inhibit (inhibit_timers),
    .clr     (clr_rd),
    .irq     (clk_irq)
  );

  always_comb begin
    rd_mux  = '0;
    ctl_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_addr == ADDR_W'(i)) rd_mux  = byte_a[i];
      if (sel_q == SEL_W'(i))     ctl_mux = mode_a[i];
    end
    if (req_addr == A_CTRL) rd_mux = ctl_mux;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      if (ctl_ok) sel_q <= sel_in;
      rsp_v_q <= rd_fire;
      if (rd_fire) rsp_d_q <= rd_mux;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;

  // R11
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  // R11
  no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid);

  // R10
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> (rsp_data == '0));

  // R2
  bad_select_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && req_addr == A_CTRL && sel_in == 2'd3) |=> $stable(sel_q));
endmodule

// File: tb/test_tmr3_bus.sv
module test_tmr3_bus;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       tick = 1'b0, gate0 = 1'b0, gate2 = 1'b0, inhibit_timers = 1'b0;
  logic       clk_irq;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #5 clk = !clk;

  tmr3_bus i_tmr3_bus (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .tick(tick), .gate0(gate0), .gate2(gate2),
    .inhibit_timers(inhibit_timers), .clk_irq(clk_irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp_valid after read", 16'(rsp_valid), 16'd1);
    d = rsp_data;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq after reset", 16'(clk_irq), 16'd0);
    chk("R1 rsp_valid after reset", 16'(rsp_valid), 16'd0);
    rd(3'd3, d); chk("R1 control read", 16'(d), 16'h00);
    rd(3'd0, d); chk("R1 data read mode 00", 16'(d), 16'h00);
    wr(3'd0, 8'h55);
    chk("R11 no rsp on write", 16'(rsp_valid), 16'd0);
  endtask

  task automatic t_single_byte();
    logic [7:0] d;
    wr(3'd3, 8'h20); wr(3'd0, 8'h12);
    rd(3'd0, d); chk("R4 high-only write", 16'(d), 16'h12);
    wr(3'd3, 8'h10);
    rd(3'd0, d); chk("R4 low byte untouched", 16'(d), 16'h00);
    wr(3'd0, 8'h34);
    rd(3'd0, d); chk("R4 low-only write", 16'(d), 16'h34);
    wr(3'd3, 8'h30);
    rd(3'd0, d); chk("R6 lohi read low", 16'(d), 16'h34);
    rd(3'd0, d); chk("R6 lohi read high", 16'(d), 16'h12);
    rd(3'd3, d); chk("R3 control read", 16'(d), 16'h30);
    wr(3'd3, 8'h00);
    rd(3'd0, d); chk("R6 mode 00 reads zero", 16'(d), 16'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(3'd3, 8'h30); wr(3'd0, 8'h05); wr(3'd0, 8'h00);
    gate0 = 1'b0; ticks(2);
    rd(3'd0, d); chk("R7 gate low shows divisor", 16'(d), 16'h05);
    rd(3'd0, d);
    gate0 = 1'b1; ticks(2);
    rd(3'd0, d); chk("R7 gate high live count", 16'(d), 16'h03);
    rd(3'd0, d); chk("R7 high byte", 16'(d), 16'h00);
  endtask

  task automatic t_counter1();
    logic [7:0] d;
    wr(3'd3, 8'h70); wr(3'd1, 8'h10); wr(3'd1, 8'h00);
    rd(3'd3, d); chk("R3 control read sel 1", 16'(d), 16'h70);
    ticks(2);
    wr(3'd3, 8'h70); wr(3'd1, 8'h08);
    ticks(2);
    rd(3'd1, d); chk("R5 toggle after low write", 16'(d), 16'h00);
    rd(3'd1, d); chk("R5 not enabled after low write", 16'(d), 16'h08);
    wr(3'd1, 8'h00);
    ticks(3);
    rd(3'd1, d); chk("R8 count after 3 ticks", 16'(d), 16'h05);
    rd(3'd1, d); chk("R6 high byte", 16'(d), 16'h00);
    ticks(4);
    chk("R9 no irq before expiry", 16'(clk_irq), 16'd0);
    ticks(1);
    chk("R9 irq on expiry", 16'(clk_irq), 16'd1);
    rd(3'd1, d); chk("R8 reload", 16'(d), 16'h08);
    rd(3'd1, d);
    rd(3'd4, d); chk("R10 clear reads zero", 16'(d), 16'h00);
    chk("R10 irq cleared", 16'(clk_irq), 16'd0);
    ticks(8);
    chk("R9 irq second expiry", 16'(clk_irq), 16'd1);
    wr(3'd4, 8'hFF);
    chk("R10 write to clear ignored", 16'(clk_irq), 16'd1);
    rd(3'd4, d);
    inhibit_timers = 1'b1; ticks(8);
    chk("R9 inhibited", 16'(clk_irq), 16'd0);
    inhibit_timers = 1'b0; ticks(7);
    @(negedge clk);
    tick = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd4;
    @(negedge clk);
    tick = 1'b0; req_valid = 1'b0;
    chk("R10 set wins over clear", 16'(clk_irq), 16'd1);
    rd(3'd4, d);
    chk("R10 cleared after", 16'(clk_irq), 16'd0);
    rd(3'd1, d); chk("R8 reload after same-cycle", 16'(d), 16'h08);
    rd(3'd1, d);
    wr(3'd3, 8'hF0);
    rd(3'd3, d); chk("R2 select 3 ignored ctl", 16'(d), 16'h70);
    ticks(2);
    rd(3'd1, d); chk("R2 counter still running", 16'(d), 16'h06);
    rd(3'd1, d); chk("R2 toggle kept", 16'(d), 16'h00);
    wr(3'd3, 8'h70);
    ticks(2);
    rd(3'd1, d); chk("R3 disabled shows divisor", 16'(d), 16'h08);
  endtask

  task automatic t_zero_div();
    logic [7:0] d;
    wr(3'd3, 8'h90); wr(3'd2, 8'h00);
    gate2 = 1'b1; ticks(1);
    rd(3'd2, d); chk("R8 divisor 0 wraps", 16'(d), 16'hFF);
    ticks(1);
    rd(3'd2, d); chk("R8 divisor 0 continues", 16'(d), 16'hFE);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_byte();
    t_gate();
    t_counter1();
    t_zero_div();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule